// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns parallel audio samples into a two-channel serial stream. It sends a bit clock, a frame sync that marks left and right, and one data line. Every stereo frame is 64 bit clocks long and holds two slots of 32 bits each. Samples enter through a valid/ready handshake. In master mode a 4-bit divider makes the bit clock from the block clock. Each slot carries one 8-bit or 16-bit sample, sent MSB first, and all slot bits after the sample are zero.

The bit clock and the frame sync each have their own drive control. If a control is set, the block makes that signal itself. If it is clear, the block follows the signal that arrives on the matching input pin. At run time the block can select standard I2S framing, where data trails the frame-sync edge by one bit, or MSB-justified framing, where the MSB comes on the same bit as the edge. It can also repeat a mono sample into both slots. When the global enable is low, the block is held idle. When the enable goes high, the block starts again at the beginning of a left slot. The mode inputs are expected to stay constant while the block is enabled.

Top module: `i2s_tx_serializer`

## Requirements
- R1: In bit-clock master mode the bit-clock period is P = max(div_sel,1)+1 block clocks. Within each period, bclk_out is low for floor(P/2) clocks and then high for the rest. sdata_out and fs_out change only on the clock edge where bclk_out falls.
- R2: A frame lasts 64 bit clocks. The frame sync is low for the 32 bits of the left slot and high for the 32 bits of the right slot. In master mode the first bit after enable is the first bit of a left slot.
- R3: With fmt_msbj=0 (I2S) the sample MSB is sent on the second bit of its slot, and the first bit of the slot is 0. With fmt_msbj=1 the MSB is sent on the first bit of the slot.
- R4: size_sel=0 sends in_data[7:0]. Any other code sends in_data[15:0]. In both cases the MSB goes first and the unused slot bits are 0.
- R5: With mono=0 one sample is fetched for each slot, left before right. With mono=1 one sample is fetched at the start of each left slot and is sent again in the right slot.
- R6: in_ready is high for exactly one clock at each fetch point. A sample is taken at the edge where in_valid and in_ready are both high.
- R7: If in_valid is low at a fetch point, underrun is high for the next clock and the slot is sent as all zeros.
- R8: With bclk_drive=0, each falling edge of bclk_in, as seen by the block clock, moves the stream forward by one bit. The outputs update one clock after the fall is detected.
- R9: With fs_drive=0, data stays 0 and nothing is fetched until a high-to-low transition of fs_in. Each low or high level of fs_in then starts the left or right slot.
- R10: One clock after en goes low, bclk_out, fs_out, sdata_out and underrun are all 0. While en is low, in_ready stays low.
- R11: bclk_oe equals bclk_drive AND en, and fs_oe equals fs_drive AND en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable |
| div_sel | input | 4 | Bit-clock divider value minus one |
| size_sel | input | 3 | Sample size code (0: 8-bit, other: 16-bit) |
| fmt_msbj | input | 1 | 1: MSB-justified, 0: I2S |
| mono | input | 1 | Repeat each sample into both slots |
| bclk_drive | input | 1 | Generate the bit clock internally |
| fs_drive | input | 1 | Generate the frame sync internally |
| bclk_in | input | 1 | External bit clock |
| fs_in | input | 1 | External frame sync |
| in_valid | input | 1 | Sample valid |
| in_data | input | 16 | Sample value |
| in_ready | output | 1 | Sample fetch strobe |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit-clock output enable |
| fs_out | output | 1 | Generated frame sync |
| fs_oe | output | 1 | Frame-sync output enable |
| sdata_out | output | 1 | Serial data |
| underrun | output | 1 | Fetch without a sample (one clock) |

## Verification
The assertions check, on every cycle, the properties that hold locally in time. Data and frame sync move only on a falling bit clock. The block is quiet one cycle after disable. in_ready appears only while the block is enabled. underrun follows only an unanswered fetch. The bench scenarios cover the rest: the length of the divided bit-clock period, the bit position of each sample inside its slot under both framings and both sizes, mono repetition, frame alignment to an external frame sync, and restart from a left slot after re-enable. These need a comparison against an arithmetic model of the whole frame.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int SLOT_BITS  = 32;
    localparam int POS_W      = 6;
    localparam int SAMPLE_W   = 16;
    localparam logic [POS_W-1:0] POS_LEFT  = 6'd0;
    localparam logic [POS_W-1:0] POS_RIGHT = 6'd32;
    localparam logic [POS_W-1:0] POS_IDLE  = 6'd63;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1
    } size_code_e;

    typedef struct packed {
        logic       msbj;
        logic       mono;
        logic [2:0] size;
    } fmt_t;

    typedef struct packed {
        logic tick;
        logic level;
    } bclk_t;

    // Place the sample at the top of the slot; the lower slot bits stay zero.
    function automatic logic [SLOT_BITS-1:0] align_sample(
        input logic [SAMPLE_W-1:0] d, input logic [2:0] code);
        logic [SLOT_BITS-1:0] w;
        if (code == SZ_BYTE) w = {d[7:0], 24'd0};
        else                 w = {d[15:0], 16'd0};
        return w;
    endfunction

    // Serial bit for slot position b. In I2S mode the MSB is delayed by one bit.
    function automatic logic slot_bit(
        input logic [SLOT_BITS-1:0] w, input logic [4:0] b, input logic msbj);
        logic [5:0] ix;
        ix = 6'd31 - {1'b0, b} + {5'd0, ~msbj};
        if (!msbj && b == 5'd0) return 1'b0;
        return w[ix[4:0]];
    endfunction

endpackage

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen
    import i2s_tx_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             drive,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             bclk_in,
    output bclk_t            bc
);
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(1);

    logic [DIV_W-1:0] cnt, cnt_nxt, dv_eff;
    logic [DIV_W:0]   period, lo_len;
    logic             lvl_q, ext_q, master_on, tick_m, tick_s;

    assign master_on = en & drive;
    assign dv_eff    = (div_sel == '0) ? DIV_MIN : div_sel;
    assign period    = {1'b0, dv_eff} + 1'b1;
    assign lo_len    = period >> 1;
    assign tick_m    = master_on & (cnt == dv_eff);
    assign cnt_nxt   = (cnt == dv_eff) ? '0 : cnt + 1'b1;
    assign tick_s    = en & ~drive & ext_q & ~bclk_in;

    always_ff @(posedge clk) begin
        if (rst || !master_on) begin
            cnt   <= '0;
            lvl_q <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            lvl_q <= ({1'b0, cnt_nxt} >= lo_len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= bclk_in;
    end

    assign bc.tick  = tick_m | tick_s;
    assign bc.level = lvl_q;

endmodule

// File: rtl/i2s_frame_ctl.sv
module i2s_frame_ctl
    import i2s_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             fs_drive,
    input  logic             tick,
    input  logic             fs_in,
    output logic [POS_W-1:0] pos_nxt,
    output logic             step,
    output logic             fs_out
);
    logic [POS_W-1:0] pos;
    logic             synced, synced_nxt, fs_prev, fs_q;

    always_comb begin
        pos_nxt    = pos;
        synced_nxt = synced;
        if (fs_drive) begin
            pos_nxt    = pos + 1'b1;
            synced_nxt = 1'b1;
        end else if (fs_prev && !fs_in) begin
            pos_nxt    = POS_LEFT;
            synced_nxt = 1'b1;
        end else if (synced && !fs_prev && fs_in) begin
            pos_nxt    = POS_RIGHT;
        end else if (synced) begin
            pos_nxt    = pos + 1'b1;
        end
    end

    assign step = tick & synced_nxt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pos     <= POS_IDLE;
            synced  <= 1'b0;
            fs_prev <= 1'b0;
            fs_q    <= 1'b0;
        end else if (tick) begin
            pos     <= pos_nxt;
            synced  <= synced_nxt;
            fs_prev <= fs_in;
            fs_q    <= fs_drive & synced_nxt & pos_nxt[POS_W-1];
        end
    end

    assign fs_out = fs_q;

endmodule

// File: rtl/i2s_slot_data.sv
module i2s_slot_data
    import i2s_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                step,
    input  logic [POS_W-1:0]    pos_nxt,
    input  fmt_t                fmt,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                in_ready,
    output logic                sdata,
    output logic                underrun
);
    logic [SLOT_BITS-1:0] wl, wr, wl_nxt, wr_nxt, fetched, cur;
    logic                 at_left, at_right, need, bit_nxt, sd_q, ur_q;

    assign at_left  = step & (pos_nxt == POS_LEFT);
    assign at_right = step & (pos_nxt == POS_RIGHT);
    assign need     = at_left | (at_right & ~fmt.mono);
    assign fetched  = in_valid ? align_sample(in_data, fmt.size) : '0;

    always_comb begin
        wl_nxt = wl;
        wr_nxt = wr;
        if (at_left) begin
            wl_nxt = fetched;
            if (fmt.mono) wr_nxt = fetched;
        end
        if (at_right && !fmt.mono) wr_nxt = fetched;
        cur     = pos_nxt[POS_W-1] ? wr_nxt : wl_nxt;
        bit_nxt = slot_bit(cur, pos_nxt[4:0], fmt.msbj);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            wl   <= '0;
            wr   <= '0;
            sd_q <= 1'b0;
            ur_q <= 1'b0;
        end else begin
            wl   <= wl_nxt;
            wr   <= wr_nxt;
            ur_q <= need & ~in_valid;
            if (step) sd_q <= bit_nxt;
        end
    end

    assign in_ready = need;
    assign sdata    = sd_q;
    assign underrun = ur_q;

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_tx_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [DIV_W-1:0]    div_sel,
    input  logic [2:0]          size_sel,
    input  logic                fmt_msbj,
    input  logic                mono,
    input  logic                bclk_drive,
    input  logic                fs_drive,
    input  logic                bclk_in,
    input  logic                fs_in,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                in_ready,
    output logic                bclk_out,
    output logic                bclk_oe,
    output logic                fs_out,
    output logic                fs_oe,
    output logic                sdata_out,
    output logic                underrun
);
    bclk_t            bc;
    fmt_t             fmt;
    logic [POS_W-1:0] pos_nxt;
    logic             step;

    assign fmt = '{msbj: fmt_msbj, mono: mono, size: size_sel};

    i2s_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .drive   (bclk_drive),
        .div_sel (div_sel),
        .bclk_in (bclk_in),
        .bc      (bc)
    );

    i2s_frame_ctl u_frame (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .fs_drive (fs_drive),
        .tick     (bc.tick),
        .fs_in    (fs_in),
        .pos_nxt  (pos_nxt),
        .step     (step),
        .fs_out   (fs_out)
    );

    i2s_slot_data u_slot (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .step     (step),
        .pos_nxt  (pos_nxt),
        .fmt      (fmt),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .sdata    (sdata_out),
        .underrun (underrun)
    );

    assign bclk_out = bc.level;
    assign bclk_oe  = bclk_drive & en;
    assign fs_oe    = fs_drive & en;

endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic in_valid,
    input logic in_ready,
    input logic bclk_out,
    input logic bclk_oe,
    input logic fs_out,
    input logic fs_oe,
    input logic sdata_out,
    input logic underrun
);
    // R10
    idle_after_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!bclk_out && !fs_out && !sdata_out && !underrun));

    // R6
    ready_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> en);

    // R7
    underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |-> $past(in_ready && !in_valid));

    // R7
    taken_no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid) |=> !underrun);

    // R1
    data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (bclk_oe && $past(bclk_oe) && !$stable(sdata_out)) |-> $fell(bclk_out));

    // R2
    fs_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (fs_oe && $past(fs_oe) && bclk_oe && $past(bclk_oe) && !$stable(fs_out))
        |-> $fell(bclk_out));

    // R11
    oe_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        (bclk_oe || fs_oe) |-> en);
endmodule

bind i2s_tx_serializer i2s_tx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .bclk_out  (bclk_out),
    .bclk_oe   (bclk_oe),
    .fs_out    (fs_out),
    .fs_oe     (fs_oe),
    .sdata_out (sdata_out),
    .underrun  (underrun)
);

// File: tb/tb_i2s_tx_serializer.sv
`timescale 1ns/1ps
module tb_i2s_tx_serializer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [3:0]  div_sel = 4'd3;
    logic [2:0]  size_sel = 3'd1;
    logic        fmt_msbj = 1'b0;
    logic        mono = 1'b0;
    logic        bclk_drive = 1'b1;
    logic        fs_drive = 1'b1;
    logic        bclk_in = 1'b0;
    logic        fs_in = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, bclk_out, bclk_oe, fs_out, fs_oe, sdata_out, underrun;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int feed_n = 0;
    int feed_idx = 0;
    logic [15:0] smp [0:15];

    always #2 clk = ~clk;

    i2s_tx_serializer dut (
        .clk(clk), .rst(rst), .en(en), .div_sel(div_sel), .size_sel(size_sel),
        .fmt_msbj(fmt_msbj), .mono(mono), .bclk_drive(bclk_drive),
        .fs_drive(fs_drive), .bclk_in(bclk_in), .fs_in(fs_in),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .bclk_out(bclk_out), .bclk_oe(bclk_oe), .fs_out(fs_out),
        .fs_oe(fs_oe), .sdata_out(sdata_out), .underrun(underrun)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    // Sample feeder: advance after each accepted handshake.
    initial begin
        forever begin
            @(negedge clk);
            if (in_valid && in_ready) begin
                @(posedge clk);
                #1;
                feed_idx++;
                in_valid = (feed_idx < feed_n);
                in_data  = (feed_idx < 16) ? smp[feed_idx] : 16'h0;
            end
        end
    end

    function automatic logic exp_bit(input int k, input logic msbj, input logic mo,
                                     input logic [2:0] sz, input int nfeed);
        int f, p, b, sidx, w, ix;
        logic [15:0] v;
        f = k / 64; p = k % 64; b = p % 32;
        sidx = mo ? f : 2 * f + p / 32;
        v = (sidx < nfeed) ? smp[sidx] : 16'h0;
        w = (sz == 3'd0) ? 8 : 16;
        ix = msbj ? b : b - 1;
        if (ix < 0 || ix >= w) return 1'b0;
        return v[w - 1 - ix];
    endfunction

    task automatic load(input int seed, input int nfeed);
        for (int i = 0; i < 16; i++) smp[i] = 16'((i + 1) * 16'h9E37) ^ 16'(seed);
        feed_n   = nfeed;
        feed_idx = 0;
        in_data  = smp[0];
        in_valid = (nfeed > 0);
    endtask

    task automatic run_master(input int dv, input logic msbj, input logic mo,
                              input logic [2:0] sz, input int nfeed, input int nf);
        int per, lo, falls, since, high, ur, fetches;
        logic prev_b;
        @(posedge clk); #1;
        en = 1'b0; div_sel = 4'(dv); fmt_msbj = msbj; mono = mo; size_sel = sz;
        bclk_drive = 1'b1; fs_drive = 1'b1;
        load(dv * 7 + 3, nfeed);
        repeat (3) @(posedge clk);
        #1 en = 1'b1;
        per = (dv == 0) ? 2 : dv + 1;
        lo = per / 2;
        falls = 0; since = 0; high = 0; ur = 0; prev_b = 1'b0;
        @(negedge clk);
        chk(bclk_oe && fs_oe, "R11 oe master", {bclk_oe, fs_oe}, 3);
        while (falls < nf * 64) begin
            @(negedge clk);
            since++;
            if (bclk_out) high++;
            if (underrun) ur++;
            if (prev_b && !bclk_out) begin
                if (falls > 0) begin
                    chk(since == per, "R1 period", since, per);
                    chk(high == per - lo, "R1 high time", high, per - lo);
                end
                // R2 frame sync, R3/R4/R5/R7 data bits; first fall is left slot start (R10 restart)
                chk(fs_out == ((falls % 64) >= 32), "R2 fs level", fs_out, (falls % 64) >= 32);
                chk(sdata_out == exp_bit(falls, msbj, mo, sz, nfeed), "R3 R4 R5 data bit",
                    sdata_out, exp_bit(falls, msbj, mo, sz, nfeed));
                falls++; since = 0; high = 0;
            end
            prev_b = bclk_out;
        end
        fetches = mo ? nf : 2 * nf;
        chk(ur == ((fetches > nfeed) ? fetches - nfeed : 0), "R7 underrun count", ur,
            (fetches > nfeed) ? fetches - nfeed : 0);
        chk(feed_idx == ((fetches < nfeed) ? fetches : nfeed), "R6 samples taken", feed_idx,
            (fetches < nfeed) ? fetches : nfeed);
    endtask

    task automatic run_slave(input logic msbj, input logic mo, input logic [2:0] sz,
                             input int nfeed, input int nf);
        int ur, fetches;
        @(posedge clk); #1;
        en = 1'b0; fmt_msbj = msbj; mono = mo; size_sel = sz;
        bclk_drive = 1'b0; fs_drive = 1'b0; bclk_in = 1'b0; fs_in = 1'b1;
        load(sz * 11 + 5, nfeed);
        repeat (3) @(posedge clk);
        #1 en = 1'b1;
        ur = 0;
        @(negedge clk);
        chk(!bclk_oe && !fs_oe, "R11 oe slave", {bclk_oe, fs_oe}, 0);
        for (int q = -3; q < nf * 64; q++) begin
            @(posedge clk); #1 bclk_in = 1'b1;
            repeat (2) @(posedge clk);
            #1 bclk_in = 1'b0;
            fs_in = (q < 0) ? 1'b1 : ((q % 64) >= 32);
            @(posedge clk);
            @(negedge clk);
            if (underrun) ur++;
            if (q < 0) begin
                chk(sdata_out == 1'b0 && !in_ready, "R9 wait for frame start", sdata_out, 0);
            end else begin
                chk(sdata_out == exp_bit(q, msbj, mo, sz, nfeed), "R8 R9 slave data bit",
                    sdata_out, exp_bit(q, msbj, mo, sz, nfeed));
                chk(bclk_out == 1'b0 && fs_out == 1'b0, "R11 slave outputs idle",
                    {bclk_out, fs_out}, 0);
            end
        end
        fetches = mo ? nf : 2 * nf;
        chk(ur == ((fetches > nfeed) ? fetches - nfeed : 0), "R7 slave underrun count", ur,
            (fetches > nfeed) ? fetches - nfeed : 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!bclk_out && !fs_out && !sdata_out && !underrun && !in_ready, "R10 reset state",
            {bclk_out, fs_out, sdata_out, underrun, in_ready}, 0);
        chk(!bclk_oe && !fs_oe, "R11 reset oe", {bclk_oe, fs_oe}, 0);
        #1 rst = 1'b0;

        run_master(3, 1'b0, 1'b0, 3'd1, 5, 3);   // I2S, 16-bit stereo, one underrun
        run_master(2, 1'b1, 1'b1, 3'd0, 2, 3);   // MSB-justified, 8-bit mono
        run_master(0, 1'b1, 1'b0, 3'd1, 4, 2);   // divider value 0 behaves as 1
        run_master(15, 1'b0, 1'b1, 3'd0, 3, 2);  // widest divider
        run_slave(1'b0, 1'b0, 3'd3, 4, 2);       // R4 unlisted size code as 16-bit
        run_slave(1'b1, 1'b1, 3'd0, 1, 2);

        // R10: disable mid-stream
        run_master(1, 1'b0, 1'b0, 3'd1, 8, 1);
        @(posedge clk); #1;
        en = 1'b0; in_valid = 1'b1;
        begin
            int held;
            held = feed_idx;
            @(posedge clk);
            @(negedge clk);
            chk(!bclk_out && !fs_out && !sdata_out && !underrun, "R10 idle after disable",
                {bclk_out, fs_out, sdata_out, underrun}, 0);
            chk(!bclk_oe && !fs_oe, "R11 oe off", {bclk_oe, fs_oe}, 0);
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                chk(!in_ready, "R10 no fetch while off", in_ready, 0);
            end
            chk(feed_idx == held, "R10 nothing taken while off", feed_idx, held);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule